// File: doc/BRIEF.md
# NAND Address Byte Sequencer

This block converts one flash access request into the series of 8-bit address bytes that a NAND device expects during its address latch phase. A request carries a page (row) address, a page-size flag, a two-bit capacity class and two enables: one for the column part and one for the page part. The number of bytes produced depends on page size and capacity. Column bytes are always zero, because the surrounding controller always moves whole pages.

Each byte leaves on a valid/ready handshake toward a downstream sequencer, which spends one address-latch cycle per byte. A new request is taken only while the block is idle. A single-cycle done pulse marks the end of a sequence. Command bytes and the data phase are handled elsewhere.

Top module: `nand_addr_seq`

## Requirements
- R1: After reset, reqReady is 1, byteValid is 0 and done is 0.
- R2: With colEn set, zero-valued column bytes are sent before any page byte: one for a small page (largePage=0, 512 bytes) and two for a large page (largePage=1, 2048 bytes).
- R3: Page bytes go out least significant first: pageAddr[7:0], then pageAddr[15:8], then pageAddr[23:16] when a third byte is due.
- R4: For a large page, the third page byte is sent exactly when capClass is 2 or 3. The encoding is 0 for below 64 MiB, 1 for 64 to 255 MiB, 2 for 256 MiB or more, and 3 is treated as 2.
- R5: For a small page, the third page byte is sent exactly when capClass is nonzero.
- R6: colEn and pageEn act independently; a part that is disabled contributes no bytes. With both cleared, no byte is sent and done still pulses.
- R7: A request is accepted at a clock edge with reqValid and reqReady both high. reqReady is high only when idle, and reqValid while busy has no effect on the bytes sent.
- R8: The first byte is valid in the cycle after acceptance. While byteValid is high and byteReady is low, byteValid and byteData hold their values.
- R9: done is high for exactly one cycle, the cycle after the last byte handshake (or the cycle after acceptance of an empty request). reqReady is high again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle, request can be taken |
| colEn | input | 1 | Send column bytes |
| pageEn | input | 1 | Send page bytes |
| largePage | input | 1 | 1: 2048-byte page, 0: 512-byte page |
| capClass | input | 2 | Device capacity class |
| pageAddr | input | 24 | Page address |
| byteValid | output | 1 | Address byte available |
| byteReady | input | 1 | Downstream takes the byte |
| byteData | output | 8 | Address byte |
| done | output | 1 | Sequence finished pulse |

## Verification
The bench sweeps every combination of the two enables, both page sizes and all four capacity classes, using three page addresses with distinct byte values. This separates byte order, byte count and column-zero errors. Each combination is run once with the downstream always ready and once with pseudo-random stalls, which exposes failures to hold a byte under backpressure. Some runs keep reqValid high with a different address while the block is busy, to show that a busy request is ignored.

// File: rtl/nas_pkg.sv
package nas_pkg;
  typedef struct packed {
    logic load;
    logic step;
    logic busy;
  } nasStrobe_t;
endpackage

// File: rtl/nas_dp.sv
module nas_dp
  import nas_pkg::*;
#(
  parameter int BYTE_W          = 8,
  parameter int ROW_BYTES_MAX   = 3,
  parameter int SMALL_COL_BYTES = 1,
  parameter int LARGE_COL_BYTES = 2,
  localparam int PAGE_W = ROW_BYTES_MAX * BYTE_W,
  localparam int CNT_W  = $clog2(LARGE_COL_BYTES + ROW_BYTES_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  nasStrobe_t        strobe,
  input  logic              colEn,
  input  logic              pageEn,
  input  logic              largePage,
  input  logic [1:0]        capClass,
  input  logic [PAGE_W-1:0] pageAddr,
  output logic [BYTE_W-1:0] byteData,
  output logic              reqEmpty,
  output logic              lastByte
);
  logic              needThird;
  logic [CNT_W-1:0]  reqCol, reqRow;
  logic [PAGE_W-1:0] pageQ;
  logic [CNT_W-1:0]  nColQ, totalQ, idxQ, rowIdx;
  logic [BYTE_W-1:0] rowByte [ROW_BYTES_MAX];
  logic              inCol;

  // byte-count decode for the incoming request
  always_comb begin
    needThird = largePage ? capClass[1] : (capClass != 2'd0);
    reqCol = '0;
    if (colEn)
      reqCol = largePage ? CNT_W'(LARGE_COL_BYTES) : CNT_W'(SMALL_COL_BYTES);
    reqRow = '0;
    if (pageEn)
      reqRow = needThird ? CNT_W'(ROW_BYTES_MAX) : CNT_W'(ROW_BYTES_MAX - 1);
    reqEmpty = (reqCol + reqRow) == '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pageQ  <= '0;
      nColQ  <= '0;
      totalQ <= '0;
      idxQ   <= '0;
    end else if (strobe.load) begin
      pageQ  <= pageAddr;
      nColQ  <= reqCol;
      totalQ <= reqCol + reqRow;
      idxQ   <= '0;
    end else if (strobe.step) begin
      idxQ <= idxQ + CNT_W'(1);
    end
  end

  generate
    for (genvar i = 0; i < ROW_BYTES_MAX; i++) begin : g_rowSlice
      assign rowByte[i] = pageQ[i*BYTE_W +: BYTE_W];
    end
  endgenerate

  assign inCol  = idxQ < nColQ;
  assign rowIdx = idxQ - nColQ;

  always_comb begin
    byteData = '0;
    if (!inCol) begin
      for (int i = 0; i < ROW_BYTES_MAX; i++)
        if (rowIdx == CNT_W'(i)) byteData = rowByte[i];
    end
  end

  assign lastByte = idxQ == (totalQ - CNT_W'(1));

  // R8
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.busy && !strobe.step |=> $stable(byteData));
  // R6
  idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.busy |-> idxQ < totalQ);
  // R2
  col_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.busy && $past(strobe.load) && nColQ != '0 |-> byteData == '0);
endmodule

// File: rtl/nas_ctrl.sv
module nas_ctrl
  import nas_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic       reqEmpty,
  input  logic       lastByte,
  input  logic       byteReady,
  output logic       reqReady,
  output logic       byteValid,
  output logic       done,
  output nasStrobe_t strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_FIN} nasState_t;
  nasState_t stateQ, stateD;

  always_comb begin
    stateD      = stateQ;
    strobe      = '0;
    reqReady    = 1'b0;
    byteValid   = 1'b0;
    done        = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.load = 1'b1;
          stateD = reqEmpty ? ST_FIN : ST_SEND;
        end
      end
      ST_SEND: begin
        byteValid   = 1'b1;
        strobe.busy = 1'b1;
        if (byteReady) begin
          strobe.step = 1'b1;
          if (lastByte) stateD = ST_FIN;
        end
      end
      ST_FIN: begin
        done   = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stateQ <= ST_IDLE;
    else        stateQ <= stateD;
  end

  // R7
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqReady |-> !byteValid && !done);
  // R8
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byteValid && !byteReady |=> byteValid);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && reqReady);
  // R8
  first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqReady && reqValid && !reqEmpty |=> byteValid);
endmodule

// File: rtl/nand_addr_seq.sv
module nand_addr_seq
  import nas_pkg::*;
#(
  parameter int BYTE_W          = 8,
  parameter int ROW_BYTES_MAX   = 3,
  parameter int SMALL_COL_BYTES = 1,
  parameter int LARGE_COL_BYTES = 2,
  localparam int PAGE_W = ROW_BYTES_MAX * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              colEn,
  input  logic              pageEn,
  input  logic              largePage,
  input  logic [1:0]        capClass,
  input  logic [PAGE_W-1:0] pageAddr,
  output logic              byteValid,
  input  logic              byteReady,
  output logic [BYTE_W-1:0] byteData,
  output logic              done
);
  nasStrobe_t strobe;
  logic       reqEmpty, lastByte;

  nas_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqEmpty(reqEmpty),
    .lastByte(lastByte), .byteReady(byteReady), .reqReady(reqReady),
    .byteValid(byteValid), .done(done), .strobe(strobe)
  );

  nas_dp #(
    .BYTE_W(BYTE_W), .ROW_BYTES_MAX(ROW_BYTES_MAX),
    .SMALL_COL_BYTES(SMALL_COL_BYTES), .LARGE_COL_BYTES(LARGE_COL_BYTES)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .colEn(colEn),
    .pageEn(pageEn), .largePage(largePage), .capClass(capClass),
    .pageAddr(pageAddr), .byteData(byteData), .reqEmpty(reqEmpty),
    .lastByte(lastByte)
  );
endmodule

// File: tb/sim_nand_addr_seq.sv
`timescale 1ns/1ps
module sim_nand_addr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0, colEn = 1'b0, pageEn = 1'b0, largePage = 1'b0;
  logic [1:0]  capClass = 2'd0;
  logic [23:0] pageAddr = '0;
  logic        byteReady = 1'b0;
  logic        reqReady, byteValid, done;
  logic [7:0]  byteData;

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  nand_addr_seq u0 (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .colEn(colEn), .pageEn(pageEn), .largePage(largePage),
    .capClass(capClass), .pageAddr(pageAddr), .byteValid(byteValid),
    .byteReady(byteReady), .byteData(byteData), .done(done)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    nChecks++;
    if (act !== expv) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic runReq(bit c, bit p, bit lg, logic [1:0] cap,
                        logic [23:0] addr, bit stall, bit poke);
    logic [7:0] expB [5];
    int nCol, nRow, total, k, guard;
    bit third, prevV, prevR;
    logic [7:0] prevD;
    third = lg ? cap[1] : (cap != 2'd0);
    nCol  = c ? (lg ? 2 : 1) : 0;
    nRow  = p ? (third ? 3 : 2) : 0;
    total = nCol + nRow;
    for (int i = 0; i < nCol; i++) expB[i] = 8'h00;
    for (int i = 0; i < nRow; i++) expB[nCol + i] = addr[i*8 +: 8];

    @(negedge clk);
    check("R7 idle ready", reqReady, 1);
    colEn = c; pageEn = p; largePage = lg; capClass = cap;
    pageAddr = addr; reqValid = 1'b1;
    @(negedge clk);
    if (poke) begin
      colEn = ~c; pageEn = 1'b1; largePage = ~lg; capClass = ~cap;
      pageAddr = ~addr;
    end else reqValid = 1'b0;
    k = 0; prevV = 0; prevR = 0; prevD = '0; guard = 0;
    while (guard < 200) begin
      guard++;
      if (k == total) begin
        // R9 done pulse after last handshake
        check("R9 done", done, 1);
        check("R9 no valid at done", byteValid, 0);
        reqValid = 1'b0; byteReady = 1'b0;
        @(negedge clk);
        check("R9 ready again", reqReady, 1);
        check("R9 done one cycle", done, 0);
        break;
      end
      check("R8 valid while bytes remain", byteValid, 1);
      check("R7 busy not ready", reqReady, 0);
      if (prevV && !prevR) check("R8 byte held", byteData, prevD);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      byteReady = stall ? lfsr[0] : 1'b1;
      if (byteReady) begin
        // R2 column zeros, R3 byte order, R4/R5 counts
        check(k < nCol ? "R2 column byte" : "R3 R4 R5 page byte",
              byteData, expB[k]);
        k++;
      end
      prevV = byteValid; prevR = byteReady; prevD = byteData;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [23:0] addrs [3];
    addrs[0] = 24'hA5C33C; addrs[1] = 24'h123456; addrs[2] = 24'hFE01B7;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 reqReady", reqReady, 1);
    check("R1 byteValid", byteValid, 0);
    check("R1 done", done, 0);
    for (int s = 0; s < 2; s++)
      for (int cfg = 0; cfg < 32; cfg++)
        for (int a = 0; a < 3; a++)
          runReq(cfg[0], cfg[1], cfg[2], cfg[4:3], addrs[a], s[0],
                 (a == 1)); // R6 via enable sweep, R7 via poke
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule